// File: doc/BRIEF.md
# Fully Associative Byte Lookup Cache

This block is a small fully associative cache stage that returns one byte per request. It keeps four lines of 64 bytes. Every line carries a tag, a valid flag and a modified flag. A request address has only two parts: a tag in its upper bits and a 6-bit byte offset in its low bits. There is no set field, so any block of memory may live in any line.

Each line has its own tag comparator. The byte selector of a line drives the addressed byte only when that line matches, and 0x00 otherwise. The per-line results are combined with a plain OR, which gives one byte and a hit flag. The lookup is combinational from stored state.

A fill port loads a whole line and its tag into a victim slot. Empty slots are used first, lowest index first. Once all slots are in use, a FIFO pointer picks the victim. A byte write that hits updates the stored line and marks it modified. When a fill replaces a modified line, the old tag and line contents are presented on a writeback output for one cycle.

Top module: `fa_byte_cache`

## Requirements
- R1: While reset is asserted and after it is released, every line is invalid: every lookup misses and `wb_valid` is 0.
- R2: A lookup hits when `req_addr[15:6]` equals the tag of a valid line. `rd_byte` is then byte `req_addr[5:0]` of that line, where byte k of a line is bits [8k+7:8k] of the line as it was filled.
- R3: On a miss, `rd_hit` is 0 and `rd_byte` is 0x00.
- R4: While any line is invalid, a fill goes into the lowest-numbered invalid line. Such a fill evicts nothing, so four fills after reset leave all four tags resident.
- R5: Once all lines are valid, each fill evicts the lines in FIFO order: slot 0, then 1, 2, 3, and back to 0. The first fill after the cache becomes full therefore evicts the line that was filled first.
- R6: A write (`req_wr`=1) that hits replaces byte `req_addr[5:0]` of the matching line with `req_wdata` and marks that line modified. A write that misses changes nothing.
- R7: A fill that evicts a valid, modified line raises `wb_valid` for exactly the one cycle after the fill edge. In that cycle `wb_tag` and `wb_data` hold the evicted line's tag and its contents, including any written bytes.
- R8: A fill that evicts a clean line, or that goes into an invalid slot, leaves `wb_valid` at 0.
- R9: A fill clears the modified flag of its slot. A line refilled into a slot that was previously modified is written back only if it is itself written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | 16 | Request address: tag in [15:6], byte offset in [5:0] |
| req_wr | input | 1 | Write the request byte into a hitting line |
| req_wdata | input | 8 | Byte to write |
| rd_hit | output | 1 | Lookup hit flag |
| rd_byte | output | 8 | Looked-up byte, 0x00 on a miss |
| fill_en | input | 1 | Load a line into the victim slot at this edge |
| fill_tag | input | 10 | Tag of the line being filled |
| fill_data | input | 512 | Line contents, byte k at bits [8k+7:8k] |
| wb_valid | output | 1 | Writeback request for an evicted modified line |
| wb_tag | output | 10 | Tag of the evicted line |
| wb_data | output | 512 | Contents of the evicted line |

## Verification
The assertions assume that a fill never brings in a tag that is already resident. This is what keeps at most one line matching. They also assume that `fill_en` and `req_wr` are never high in the same cycle. The stimulus uses a distinct tag for every fill, except when a tag is refilled after it has been evicted and seen to miss. Writes and fills are issued in separate cycles.

// File: rtl/fab_pkg.sv
package fab_pkg;

  typedef struct packed {
    logic valid;
    logic dirty;
  } line_flags_t;

endpackage

// File: rtl/fab_lane.sv
module fab_lane
  import fab_pkg::*;
#(
  parameter int TAG_W      = 10,
  parameter int OFF_W      = 6,
  parameter int LINE_BYTES = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [TAG_W-1:0]          lk_tag,
  input  logic [OFF_W-1:0]          lk_off,
  input  logic                      fill_we,
  input  logic [TAG_W-1:0]          fill_tag,
  input  logic [LINE_BYTES*8-1:0]   fill_data,
  input  logic                      wr_we,
  input  logic [7:0]                wr_data,
  output logic                      match,
  output logic [7:0]                lane_byte,
  output line_flags_t               flags,
  output logic [TAG_W-1:0]          line_tag,
  output logic [LINE_BYTES*8-1:0]   line_data
);

  localparam int LINE_W = LINE_BYTES * 8;

  logic              valid_q, valid_d;
  logic              dirty_q, dirty_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [LINE_W-1:0] data_q, data_d;
  logic              data_en;
  logic              tag_eq;

  // comparator: all tag bits must agree
  assign tag_eq = (tag_q == lk_tag);
  assign match  = valid_q & tag_eq;

  // selector forces zero when this lane does not match
  assign lane_byte = match ? data_q[{lk_off, 3'b000} +: 8] : 8'h00;

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    tag_d   = tag_q;
    data_d  = data_q;
    data_en = 1'b0;
    if (fill_we) begin
      valid_d = 1'b1;
      dirty_d = 1'b0;
      tag_d   = fill_tag;
      data_d  = fill_data;
      data_en = 1'b1;
    end else if (wr_we) begin
      dirty_d = 1'b1;
      data_d[{lk_off, 3'b000} +: 8] = wr_data;
      data_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      dirty_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
      tag_q   <= tag_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_en) begin
      data_q <= data_d;
    end
  end

  assign flags.valid = valid_q;
  assign flags.dirty = dirty_q;
  assign line_tag    = tag_q;
  assign line_data   = data_q;

  // R6: a hitting write leaves the line modified
  a_r6_write_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_we && !fill_we) |=> dirty_q);

  // R9: a fill leaves the slot valid and clean
  a_r9_fill_clean: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> (valid_q && !dirty_q));

endmodule

// File: rtl/fab_victim.sv
module fab_victim #(
  parameter int LINES = 4,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [LINES-1:0] valid_vec,
  output logic [IDX_W-1:0] victim_idx,
  output logic [LINES-1:0] victim_oh
);

  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [IDX_W-1:0] free_idx;
  logic             any_free;
  logic             ptr_en;

  // lowest-numbered invalid line
  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  assign victim_idx = any_free ? free_idx : ptr_q;

  always_comb begin
    victim_oh = '0;
    victim_oh[victim_idx] = 1'b1;
  end

  assign ptr_en = fill_en & ~any_free;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_en) begin
      ptr_d = (ptr_q == IDX_W'(LINES - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  // R4: while a slot is empty, the chosen victim is an empty slot
  a_r4_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !(&valid_vec)) |-> !valid_vec[victim_idx]);

  // R5: pointer only moves on a fill that evicts a valid line
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_en && (&valid_vec)) |=> $stable(ptr_q));

  a_r5_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && (&valid_vec)) |=> (ptr_q != $past(ptr_q)));

endmodule

// File: rtl/fab_merge.sv
module fab_merge #(
  parameter int LINES = 4
) (
  input  logic [LINES-1:0]      match_vec,
  input  logic [LINES-1:0][7:0] lane_bytes,
  output logic                  hit,
  output logic [7:0]            byte_out
);

  always_comb begin
    hit      = 1'b0;
    byte_out = 8'h00;
    for (int i = 0; i < LINES; i++) begin
      hit      = hit | match_vec[i];
      byte_out = byte_out | lane_bytes[i];
    end
  end

endmodule

// File: rtl/fa_byte_cache.sv
module fa_byte_cache
  import fab_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINES      = 4,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - OFF_W,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int IDX_W     = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wr,
  input  logic [7:0]        req_wdata,
  output logic              rd_hit,
  output logic [7:0]        rd_byte,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_data,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [LINE_W-1:0] wb_data
);

  logic [TAG_W-1:0]       lk_tag;
  logic [OFF_W-1:0]       lk_off;
  logic [LINES-1:0]       match_vec;
  logic [LINES-1:0]       valid_vec;
  logic [LINES-1:0]       dirty_vec;
  logic [LINES-1:0][7:0]  lane_bytes;
  logic [LINES-1:0]       fill_we;
  logic [LINES-1:0]       wr_we;
  logic [LINES-1:0]       victim_oh;
  logic [IDX_W-1:0]       victim_idx;
  line_flags_t            flags [LINES];
  logic [TAG_W-1:0]       line_tag [LINES];
  logic [LINE_W-1:0]      line_data [LINES];

  logic                   wb_valid_d;
  logic                   wb_cap;

  assign lk_tag = req_addr[ADDR_W-1:OFF_W];
  assign lk_off = req_addr[OFF_W-1:0];

  generate
    for (genvar g = 0; g < LINES; g++) begin : g_lane
      assign fill_we[g]   = fill_en & victim_oh[g];
      assign wr_we[g]     = req_wr & ~fill_en & match_vec[g];
      assign valid_vec[g] = flags[g].valid;
      assign dirty_vec[g] = flags[g].dirty;

      fab_lane #(
        .TAG_W      (TAG_W),
        .OFF_W      (OFF_W),
        .LINE_BYTES (LINE_BYTES)
      ) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_tag    (lk_tag),
        .lk_off    (lk_off),
        .fill_we   (fill_we[g]),
        .fill_tag  (fill_tag),
        .fill_data (fill_data),
        .wr_we     (wr_we[g]),
        .wr_data   (req_wdata),
        .match     (match_vec[g]),
        .lane_byte (lane_bytes[g]),
        .flags     (flags[g]),
        .line_tag  (line_tag[g]),
        .line_data (line_data[g])
      );
    end
  endgenerate

  fab_victim #(
    .LINES (LINES)
  ) u_victim (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (fill_en),
    .valid_vec  (valid_vec),
    .victim_idx (victim_idx),
    .victim_oh  (victim_oh)
  );

  fab_merge #(
    .LINES (LINES)
  ) u_merge (
    .match_vec  (match_vec),
    .lane_bytes (lane_bytes),
    .hit        (rd_hit),
    .byte_out   (rd_byte)
  );

  // writeback capture of a modified victim
  assign wb_cap     = fill_en & valid_vec[victim_idx] & dirty_vec[victim_idx];
  assign wb_valid_d = wb_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
    end else begin
      wb_valid <= wb_valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wb_cap) begin
      wb_tag  <= line_tag[victim_idx];
      wb_data <= line_data[victim_idx];
    end
  end

  // R2: a well-formed fill stream never makes two lanes match
  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  // R3: a miss yields a zero byte
  a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |-> (rd_byte == 8'h00));

  // R7: a writeback request follows a fill
  a_r7_wb_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(fill_en));

  // R8: replacing a clean or empty slot raises no writeback
  a_r8_clean_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !(valid_vec[victim_idx] && dirty_vec[victim_idx])) |=> !wb_valid);

endmodule

// File: tb/fa_byte_cache_test.sv
module fa_byte_cache_test;

  localparam int NV = 23;

  // vector: {op[1:0], addr[15:0], wdata[7:0], exp_flag, use_pat, exp_byte[7:0]}
  // op 0 = lookup (exp_flag = expected hit), 1 = fill (exp_flag = expected wb), 2 = write
  localparam logic [35:0] VEC [NV] = '{
    {2'd0, 10'h011, 6'd5,  8'h00, 1'b0, 1'b0, 8'h00}, // R1 R3 empty
    {2'd1, 10'h011, 6'd0,  8'h00, 1'b0, 1'b0, 8'h00}, // fill A, R8
    {2'd0, 10'h011, 6'd0,  8'h00, 1'b1, 1'b1, 8'h00}, // R2
    {2'd0, 10'h011, 6'd63, 8'h00, 1'b1, 1'b1, 8'h00}, // R2
    {2'd0, 10'h022, 6'd3,  8'h00, 1'b0, 1'b0, 8'h00}, // R3
    {2'd1, 10'h022, 6'd0,  8'h00, 1'b0, 1'b0, 8'h00}, // R4
    {2'd1, 10'h033, 6'd0,  8'h00, 1'b0, 1'b0, 8'h00}, // R4
    {2'd1, 10'h044, 6'd0,  8'h00, 1'b0, 1'b0, 8'h00}, // R4
    {2'd0, 10'h011, 6'd10, 8'h00, 1'b1, 1'b1, 8'h00}, // R4
    {2'd0, 10'h044, 6'd33, 8'h00, 1'b1, 1'b1, 8'h00}, // R4
    {2'd0, 10'h022, 6'd1,  8'h00, 1'b1, 1'b1, 8'h00}, // R4
    {2'd0, 10'h033, 6'd62, 8'h00, 1'b1, 1'b1, 8'h00}, // R4
    {2'd2, 10'h022, 6'd7,  8'hC3, 1'b0, 1'b0, 8'h00}, // R6 hit write
    {2'd0, 10'h022, 6'd7,  8'h00, 1'b1, 1'b0, 8'hC3}, // R6
    {2'd2, 10'h066, 6'd7,  8'h99, 1'b0, 1'b0, 8'h00}, // R6 miss write
    {2'd0, 10'h066, 6'd7,  8'h00, 1'b0, 1'b0, 8'h00}, // R6
    {2'd0, 10'h022, 6'd8,  8'h00, 1'b1, 1'b1, 8'h00}, // R6 neighbour
    {2'd1, 10'h055, 6'd0,  8'h00, 1'b0, 1'b0, 8'h00}, // R5 evict A clean, R8
    {2'd0, 10'h011, 6'd10, 8'h00, 1'b0, 1'b0, 8'h00}, // R5
    {2'd0, 10'h055, 6'd20, 8'h00, 1'b1, 1'b1, 8'h00}, // R5
    {2'd1, 10'h011, 6'd0,  8'h00, 1'b1, 1'b0, 8'h00}, // R5 evict B dirty, R7
    {2'd0, 10'h022, 6'd7,  8'h00, 1'b0, 1'b0, 8'h00}, // R5
    {2'd0, 10'h033, 6'd0,  8'h00, 1'b1, 1'b1, 8'h00}  // R5
  };

  logic         clk;
  logic         rst_n;
  logic [15:0]  req_addr;
  logic         req_wr;
  logic [7:0]   req_wdata;
  logic         rd_hit;
  logic [7:0]   rd_byte;
  logic         fill_en;
  logic [9:0]   fill_tag;
  logic [511:0] fill_data;
  logic         wb_valid;
  logic [9:0]   wb_tag;
  logic [511:0] wb_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  fa_byte_cache uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_addr  (req_addr),
    .req_wr    (req_wr),
    .req_wdata (req_wdata),
    .rd_hit    (rd_hit),
    .rd_byte   (rd_byte),
    .fill_en   (fill_en),
    .fill_tag  (fill_tag),
    .fill_data (fill_data),
    .wb_valid  (wb_valid),
    .wb_tag    (wb_tag),
    .wb_data   (wb_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [9:0] t, input int k);
    return 8'(t[7:0] * 8'd3) ^ 8'(k * 37 + 11) ^ {6'd0, t[9:8]};
  endfunction

  function automatic logic [511:0] line_of(input logic [9:0] t);
    logic [511:0] l;
    for (int k = 0; k < 64; k++) l[k*8 +: 8] = pat(t, k);
    return l;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [9:0] t, input logic [5:0] off, input bit exp_hit,
                        input logic [7:0] exp_byte, input string req);
    @(negedge clk);
    req_addr = {t, off};
    #1;
    check(rd_hit == exp_hit, req, 32'(rd_hit), 32'(exp_hit));
    check(rd_byte == exp_byte, req, 32'(rd_byte), 32'(exp_byte));
  endtask

  task automatic fill(input logic [9:0] t, input bit exp_wb, input logic [9:0] exp_tag,
                      input string req);
    @(negedge clk);
    fill_en   = 1'b1;
    fill_tag  = t;
    fill_data = line_of(t);
    @(negedge clk);
    fill_en = 1'b0;
    #1;
    check(wb_valid == exp_wb, req, 32'(wb_valid), 32'(exp_wb));
    if (exp_wb) check(wb_tag == exp_tag, req, 32'(wb_tag), 32'(exp_tag));
  endtask

  task automatic write(input logic [9:0] t, input logic [5:0] off, input logic [7:0] d);
    @(negedge clk);
    req_addr  = {t, off};
    req_wdata = d;
    req_wr    = 1'b1;
    @(negedge clk);
    req_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    req_addr  = '0;
    req_wr    = 1'b0;
    req_wdata = '0;
    fill_en   = 1'b0;
    fill_tag  = '0;
    fill_data = '0;
    repeat (3) @(negedge clk);
    #1;
    check(rd_hit == 1'b0, "R1", 32'(rd_hit), 0);
    check(wb_valid == 1'b0, "R1", 32'(wb_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      logic [9:0]  t;
      logic [5:0]  off;
      logic [7:0]  eb;
      v   = VEC[i];
      t   = v[33:24];
      off = v[23:18];
      eb  = v[8] ? pat(t, int'(off)) : v[7:0];
      case (v[35:34])
        2'd0: lookup(t, off, v[9], v[9] ? eb : 8'h00, "R2/R3/R5/R6 table");
        2'd1: fill(t, v[9], 10'h022, "R4/R5/R7/R8 table");
        default: write(t, off, v[17:10]);
      endcase
    end

    // reset in the middle of activity
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(rd_hit == 1'b0, "R1", 32'(rd_hit), 0);
    @(negedge clk);
    rst_n = 1'b1;
    lookup(10'h033, 6'd0, 1'b0, 8'h00, "R1");

    // dirty eviction with full contents
    fill(10'h101, 1'b0, 10'h0, "R8");
    fill(10'h102, 1'b0, 10'h0, "R8");
    fill(10'h103, 1'b0, 10'h0, "R8");
    fill(10'h104, 1'b0, 10'h0, "R8");
    write(10'h101, 6'd0, 8'hAB);
    write(10'h101, 6'd63, 8'hCD);
    lookup(10'h101, 6'd63, 1'b1, 8'hCD, "R6");
    fill(10'h105, 1'b1, 10'h101, "R7");
    check(wb_data[7:0] == 8'hAB, "R7", 32'(wb_data[7:0]), 32'hAB);
    check(wb_data[511:504] == 8'hCD, "R7", 32'(wb_data[511:504]), 32'hCD);
    check(wb_data[15:8] == pat(10'h101, 1), "R7", 32'(wb_data[15:8]),
          32'(pat(10'h101, 1)));
    @(negedge clk);
    #1;
    check(wb_valid == 1'b0, "R7", 32'(wb_valid), 0);
    lookup(10'h101, 6'd0, 1'b0, 8'h00, "R5");

    // refilled slot 0 is clean: later eviction writes nothing back
    fill(10'h106, 1'b0, 10'h0, "R8");
    fill(10'h107, 1'b0, 10'h0, "R8");
    fill(10'h108, 1'b0, 10'h0, "R8");
    fill(10'h109, 1'b0, 10'h0, "R9");
    lookup(10'h105, 6'd4, 1'b0, 8'h00, "R9");
    lookup(10'h109, 6'd4, 1'b1, pat(10'h109, 4), "R2");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule